// File: doc/BRIEF.md
# Auto-Indexed Pointer Transfer Unit

This unit moves one byte between an accumulator and memory through one of two address pointers, then steps that pointer by one. A single opcode byte selects the pointer, the step direction and the kind of transfer. A load copies the addressed byte into the accumulator. An exchange reads the byte and then writes the old accumulator value back to the same address, so the two values trade places.

The first pointer is bounded. After it steps, it is compared with a limit register, unsigned. When an incrementing operation carries it above the limit, or a decrementing one carries it below, the unit raises a one-cycle skip request so the instruction sequencer can pass over the next instruction. This lets a copy or scan loop end without a separate compare and branch. The second pointer steps the same way but never raises a skip.

Memory is reached through a request/acknowledge port. A request is held until the cycle in which the acknowledge is sampled, so the port works with any number of wait cycles. A small write port loads the accumulator, both pointers and the limit while the unit is idle.

Top module: `ptr_xfer_unit`

## Requirements
- R1: An opcode is accepted only when `op_valid` is high, the unit is idle, and `op_byte[7:3]` equals 5'b10100. Bit 2 selects the pointer (0 bounded pointer, 1 plain pointer), bit 1 the step (0 increment, 1 decrement), bit 0 the kind (0 load, 1 exchange). Any other byte, and any opcode offered while busy, starts no memory cycle and changes no register.
- R2: A load makes exactly one read at the selected pointer's address, and the accumulator takes the read data.
- R3: An exchange makes one read and then one write at the same address. The write data is the accumulator value from before the operation, and the accumulator ends with the old memory byte.
- R4: When the transfer completes, the selected pointer becomes its old value plus or minus one, modulo 2^16. The other pointer and the limit are unchanged.
- R5: For increment forms on the bounded pointer, `skip` is raised exactly when the stepped pointer is greater than the limit (unsigned).
- R6: For decrement forms on the bounded pointer, `skip` is raised exactly when the stepped pointer is less than the limit (unsigned).
- R7: Operations on the plain pointer never raise `skip`, whatever the pointer and limit hold.
- R8: `done` and `skip` are registered one-cycle pulses. They go high in the cycle that follows the edge at which the final acknowledge is sampled. A load therefore completes `lat+1` cycles after acceptance and an exchange `2*(lat+1)` cycles after, where `lat` is the wait cycles per access. `busy` is high from acceptance until completion.
- R9: `mem_rd` and `mem_wr` are never high together. A request and its `mem_addr` stay unchanged until the acknowledge is sampled.
- R10: `cfg_sel` selects the register that `cfg_we` writes: 0 accumulator (low `DATA_W` bits), 1 bounded pointer, 2 limit, 3 plain pointer. Writes offered while `busy` is high are ignored.
- R11: Synchronous reset clears all four registers, drops `busy`, `done`, `skip`, `mem_rd` and `mem_wr`, and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte is present |
| op_byte | input | 8 | Opcode byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | ADDR_W | Register write data |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with acknowledge |
| mem_ack | input | 1 | Acknowledge for the pending request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | One-cycle skip-next-instruction request |
| acc | output | DATA_W | Accumulator |
| ptr_b | output | ADDR_W | Bounded pointer |
| lim_k | output | ADDR_W | Limit register |
| ptr_x | output | ADDR_W | Plain pointer |

## Verification
Each result is sampled on the falling edge. `done` and `skip` are due `lat+1` falling edges after the opcode is accepted for a load and `2*(lat+1)` for an exchange, where the bench's memory model sets the wait count for each vector. The bench counts falling edges until `done` appears and compares that count with the figure from R8. It then reads the accumulator, pointers, limit and memory on that same edge, and checks one edge later that both pulses have dropped. Tests of opcodes that should be ignored wait several edges before confirming that no access was made and no register moved.

// File: rtl/apu_pkg.sv
package apu_pkg;

    typedef enum logic {PTR_B = 1'b0, PTR_X = 1'b1} ptr_sel_e;
    typedef enum logic {STEP_INC = 1'b0, STEP_DEC = 1'b1} step_dir_e;
    typedef enum logic {XFER_LOAD = 1'b0, XFER_SWAP = 1'b1} xfer_kind_e;

    typedef struct packed {
        ptr_sel_e   ptr;
        step_dir_e  dir;
        xfer_kind_e kind;
    } xfer_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        CFG_ACC = 2'd0,
        CFG_PB  = 2'd1,
        CFG_LIM = 2'd2,
        CFG_PX  = 2'd3
    } cfg_sel_e;

    localparam int OP_W = 8;
    localparam logic [4:0] OP_FAMILY = 5'b10100;

    function automatic logic op_in_family(input logic [OP_W-1:0] op);
        return op[OP_W-1:3] == OP_FAMILY;
    endfunction

    function automatic xfer_cmd_t op_fields(input logic [OP_W-1:0] op);
        xfer_cmd_t c;
        c.ptr  = ptr_sel_e'(op[2]);
        c.dir  = step_dir_e'(op[1]);
        c.kind = xfer_kind_e'(op[0]);
        return c;
    endfunction

endpackage

// File: rtl/apu_decode.sv
module apu_decode
    import apu_pkg::*;
(
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_byte,
    output logic            op_go,
    output xfer_cmd_t       op_cmd
);

    always_comb begin
        op_go  = op_valid && op_in_family(op_byte);
        op_cmd = op_fields(op_byte);
    end

endmodule

// File: rtl/apu_step.sv
module apu_step
    import apu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter bit BOUNDED = 1'b1
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] limit,
    input  step_dir_e         dir,
    output logic [ADDR_W-1:0] nxt,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (dir == STEP_DEC) nxt = cur - ONE;
        else                 nxt = cur + ONE;
    end

    generate
        if (BOUNDED) begin : g_bounded
            always_comb begin
                if (dir == STEP_DEC) hit = (nxt < limit);
                else                 hit = (nxt > limit);
            end
        end else begin : g_plain
            logic unused_limit;
            assign unused_limit = ^limit;
            assign hit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/apu_ctrl.sv
module apu_ctrl
    import apu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      op_go,
    input  xfer_cmd_t op_cmd,
    input  logic      mem_ack,
    input  logic      step_hit,
    output xfer_cmd_t cmd_q,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      capture,
    output logic      commit,
    output logic      busy,
    output logic      done,
    output logic      skip
);

    xfer_state_e state_q;

    always_comb begin
        mem_rd  = (state_q == ST_READ);
        mem_wr  = (state_q == ST_WRITE);
        busy    = (state_q != ST_IDLE);
        capture = mem_rd && mem_ack;
        commit  = (mem_rd && mem_ack && cmd_q.kind == XFER_LOAD) ||
                  (mem_wr && mem_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            done    <= 1'b0;
            skip    <= 1'b0;
        end else begin
            done <= commit;
            skip <= commit && step_hit;
            case (state_q)
                ST_IDLE: begin
                    if (op_go) begin
                        cmd_q   <= op_cmd;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ack)
                        state_q <= (cmd_q.kind == XFER_SWAP) ? ST_WRITE : ST_IDLE;
                end
                ST_WRITE: begin
                    if (mem_ack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_req_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr))
        else $error("read and write requested together");

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ack) |=> mem_rd)
        else $error("read request dropped before acknowledge");

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack) |=> mem_wr)
        else $error("write request dropped before acknowledge");

    p_skip_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        skip |=> !skip)
        else $error("skip held longer than one cycle");

    p_skip_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        skip |-> done)
        else $error("skip without completion");

    p_plain_noskip_r7: assert property (@(posedge clk) disable iff (rst)
        (done && cmd_q.ptr == PTR_X) |-> !skip)
        else $error("plain pointer raised skip");

endmodule

// File: rtl/apu_regs.sv
module apu_regs
    import apu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              capture,
    input  logic              commit,
    input  xfer_cmd_t         cmd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] next_b,
    input  logic [ADDR_W-1:0] next_x,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] ptr_b,
    output logic [ADDR_W-1:0] lim_k,
    output logic [ADDR_W-1:0] ptr_x
);

    logic [DATA_W-1:0] rd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            ptr_b   <= '0;
            lim_k   <= '0;
            ptr_x   <= '0;
            rd_hold <= '0;
        end else begin
            if (capture) rd_hold <= mem_rdata;
            if (cfg_en) begin
                case (cfg_sel_e'(cfg_sel))
                    CFG_ACC: acc   <= cfg_wdata[DATA_W-1:0];
                    CFG_PB:  ptr_b <= cfg_wdata;
                    CFG_LIM: lim_k <= cfg_wdata;
                    CFG_PX:  ptr_x <= cfg_wdata;
                    default: ;
                endcase
            end
            if (commit) begin
                acc <= (cmd.kind == XFER_SWAP) ? rd_hold : mem_rdata;
                if (cmd.ptr == PTR_B) ptr_b <= next_b;
                else                  ptr_x <= next_x;
            end
        end
    end

    p_step_b_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.ptr == PTR_B) |=> (ptr_b != $past(ptr_b)) && $stable(ptr_x))
        else $error("bounded pointer step wrong");

    p_step_x_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.ptr == PTR_X) |=> (ptr_x != $past(ptr_x)) && $stable(ptr_b))
        else $error("plain pointer step wrong");

    p_limit_kept_r4: assert property (@(posedge clk) disable iff (rst)
        commit |=> $stable(lim_k))
        else $error("limit changed by a transfer");

endmodule

// File: rtl/ptr_xfer_unit.sv
module ptr_xfer_unit
    import apu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              skip,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] ptr_b,
    output logic [ADDR_W-1:0] lim_k,
    output logic [ADDR_W-1:0] ptr_x
);

    localparam int NPTR = 2;

    logic      op_go;
    xfer_cmd_t op_cmd;
    xfer_cmd_t cmd_q;
    logic      capture;
    logic      commit;
    logic      step_hit;

    logic [ADDR_W-1:0] cur_ptr [NPTR];
    logic [ADDR_W-1:0] nxt_ptr [NPTR];
    logic              hit     [NPTR];

    apu_decode u_dec (
        .op_valid (op_valid),
        .op_byte  (op_byte),
        .op_go    (op_go),
        .op_cmd   (op_cmd)
    );

    apu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op_go    (op_go),
        .op_cmd   (op_cmd),
        .mem_ack  (mem_ack),
        .step_hit (step_hit),
        .cmd_q    (cmd_q),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .capture  (capture),
        .commit   (commit),
        .busy     (busy),
        .done     (done),
        .skip     (skip)
    );

    assign cur_ptr[0] = ptr_b;
    assign cur_ptr[1] = ptr_x;

    genvar g;
    generate
        for (g = 0; g < NPTR; g++) begin : g_step
            apu_step #(
                .ADDR_W  (ADDR_W),
                .BOUNDED (g == 0)
            ) u_step (
                .cur   (cur_ptr[g]),
                .limit (lim_k),
                .dir   (cmd_q.dir),
                .nxt   (nxt_ptr[g]),
                .hit   (hit[g])
            );
        end
    endgenerate

    assign step_hit  = (cmd_q.ptr == PTR_B) ? hit[0] : hit[1];
    assign mem_addr  = (cmd_q.ptr == PTR_B) ? ptr_b : ptr_x;
    assign mem_wdata = acc;

    apu_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_we && !busy),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .capture   (capture),
        .commit    (commit),
        .cmd       (cmd_q),
        .mem_rdata (mem_rdata),
        .next_b    (nxt_ptr[0]),
        .next_x    (nxt_ptr[1]),
        .acc       (acc),
        .ptr_b     (ptr_b),
        .lim_k     (lim_k),
        .ptr_x     (ptr_x)
    );

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ack) |=> $stable(mem_addr))
        else $error("address moved during a pending request");

    p_busy_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("completion pulse while still busy");

endmodule

// File: tb/sim_ptr_xfer_unit.sv
`timescale 1ns/1ps
module sim_ptr_xfer_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ack;
    logic        busy, done, skip;
    logic [7:0]  acc;
    logic [15:0] ptr_b, lim_k, ptr_x;

    always #5 clk = ~clk;

    ptr_xfer_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .skip(skip),
        .acc(acc), .ptr_b(ptr_b), .lim_k(lim_k), .ptr_x(ptr_x)
    );

    // memory model with programmable wait cycles
    logic [7:0]  mem [0:255];
    logic        pre_we = 1'b0;
    logic [7:0]  pre_addr = 8'h0;
    logic [7:0]  pre_data = 8'h0;
    int          lat = 0;
    int          wcnt = 0;
    logic        ack_q = 1'b0;
    int          n_rd = 0, n_wr = 0, hold_err = 0, overlap = 0;
    logic [15:0] last_rd_addr = 16'h0, last_wr_addr = 16'h0;
    logic        was_wait = 1'b0;
    logic [15:0] wait_addr = 16'h0;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ack   = ack_q;

    always @(negedge clk) begin
        if (ack_q) wcnt = 0;
        if ((mem_rd || mem_wr) && wcnt >= lat) ack_q = 1'b1;
        else begin
            ack_q = 1'b0;
            if (mem_rd || mem_wr) wcnt = wcnt + 1;
        end
        if (mem_rd && mem_wr) overlap = overlap + 1;
    end

    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
        if (was_wait && (mem_rd || mem_wr) && mem_addr != wait_addr)
            hold_err = hold_err + 1;
        was_wait  = (mem_rd || mem_wr) && !mem_ack;
        wait_addr = mem_addr;
        if (mem_rd && mem_ack) begin
            n_rd = n_rd + 1;
            last_rd_addr = mem_addr;
        end
        if (mem_wr && mem_ack) begin
            n_wr = n_wr + 1;
            last_wr_addr = mem_addr;
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] s, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] op);
        op_valid = 1'b1; op_byte = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  acc0;
        logic [15:0] b0;
        logic [15:0] k0;
        logic [15:0] x0;
        logic [7:0]  mval;
        logic [3:0]  lat;
        logic [7:0]  e_acc;
        logic [15:0] e_b;
        logic [15:0] e_x;
        logic        e_skip;
        logic [7:0]  e_mem;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [0:NV-1] = '{
        '{8'hA0, 8'h11, 16'h0010, 16'h0020, 16'h0100, 8'h5A, 4'd0, 8'h5A, 16'h0011, 16'h0100, 1'b0, 8'h5A},
        '{8'hA0, 8'h11, 16'h0020, 16'h0020, 16'h0000, 8'h33, 4'd1, 8'h33, 16'h0021, 16'h0000, 1'b1, 8'h33},
        '{8'hA1, 8'hC3, 16'h001F, 16'h0020, 16'h0000, 8'h77, 4'd2, 8'h77, 16'h0020, 16'h0000, 1'b0, 8'hC3},
        '{8'hA1, 8'h01, 16'h0020, 16'h0020, 16'h0000, 8'h88, 4'd0, 8'h88, 16'h0021, 16'h0000, 1'b1, 8'h01},
        '{8'hA2, 8'h00, 16'h0021, 16'h0020, 16'h0000, 8'h44, 4'd0, 8'h44, 16'h0020, 16'h0000, 1'b0, 8'h44},
        '{8'hA2, 8'h00, 16'h0020, 16'h0020, 16'h0000, 8'h45, 4'd1, 8'h45, 16'h001F, 16'h0000, 1'b1, 8'h45},
        '{8'hA3, 8'h9A, 16'h0000, 16'h0000, 16'h0000, 8'h12, 4'd0, 8'h12, 16'hFFFF, 16'h0000, 1'b0, 8'h9A},
        '{8'hA1, 8'h05, 16'hFFFF, 16'h0000, 16'h0000, 8'h66, 4'd3, 8'h66, 16'h0000, 16'h0000, 1'b0, 8'h05},
        '{8'hA0, 8'h00, 16'h7FFF, 16'h7FFF, 16'h0000, 8'h21, 4'd0, 8'h21, 16'h8000, 16'h0000, 1'b1, 8'h21},
        '{8'hA4, 8'h00, 16'h0030, 16'h0000, 16'h0040, 8'h9C, 4'd0, 8'h9C, 16'h0030, 16'h0041, 1'b0, 8'h9C},
        '{8'hA5, 8'hAB, 16'h0005, 16'h0001, 16'h00FF, 8'hCD, 4'd1, 8'hCD, 16'h0005, 16'h0100, 1'b0, 8'hAB},
        '{8'hA6, 8'h00, 16'h0000, 16'hFFFF, 16'h0000, 8'h3E, 4'd0, 8'h3E, 16'h0000, 16'hFFFF, 1'b0, 8'h3E},
        '{8'hA7, 8'h7E, 16'h0010, 16'h0020, 16'h0080, 8'hE7, 4'd2, 8'hE7, 16'h0010, 16'h007F, 1'b0, 8'h7E},
        '{8'hA3, 8'h10, 16'h0001, 16'h0005, 16'h0000, 8'h20, 4'd1, 8'h20, 16'h0000, 16'h0000, 1'b1, 8'h10}
    };

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
        $finish;
    end

    initial begin
        int cyc;
        int rd0, wr0;
        logic [15:0] a;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        chk("R11 acc", {24'h0, acc}, 32'h0);
        chk("R11 regs", {ptr_b, ptr_x}, 32'h0);
        chk("R11 limit", {16'h0, lim_k}, 32'h0);
        chk("R11 outputs", {27'h0, busy, done, skip, mem_rd, mem_wr}, 32'h0);

        // table of vectors: R2..R8, R10 writes
        for (int i = 0; i < NV; i++) begin
            cfg_wr(2'd0, {8'h00, VEC[i].acc0});
            cfg_wr(2'd1, VEC[i].b0);
            cfg_wr(2'd2, VEC[i].k0);
            cfg_wr(2'd3, VEC[i].x0);
            a = VEC[i].op[2] ? VEC[i].x0 : VEC[i].b0;
            poke(a[7:0], VEC[i].mval);
            lat = int'(VEC[i].lat);
            rd0 = n_rd; wr0 = n_wr;
            chk("R10 cfg readback", {VEC[i].acc0, 8'h00, lim_k}, {acc, 8'h00, VEC[i].k0});
            issue(VEC[i].op);
            wait_done(cyc);
            chk($sformatf("R8 latency v%0d", i), cyc,
                (VEC[i].op[0] ? 2 : 1) * (int'(VEC[i].lat) + 1));
            chk($sformatf("R5 R6 R7 skip v%0d", i), {31'h0, skip}, {31'h0, VEC[i].e_skip});
            chk($sformatf("R2 R3 acc v%0d", i), {24'h0, acc}, {24'h0, VEC[i].e_acc});
            chk($sformatf("R4 pointers v%0d", i), {ptr_b, ptr_x}, {VEC[i].e_b, VEC[i].e_x});
            chk($sformatf("R4 limit v%0d", i), {16'h0, lim_k}, {16'h0, VEC[i].k0});
            chk($sformatf("R3 memory v%0d", i), {24'h0, mem[a[7:0]]}, {24'h0, VEC[i].e_mem});
            chk($sformatf("R2 R3 counts v%0d", i), n_rd - rd0 + 16 * (n_wr - wr0),
                1 + 16 * int'(VEC[i].op[0]));
            chk($sformatf("R2 address v%0d", i), {16'h0, last_rd_addr}, {16'h0, a});
            if (VEC[i].op[0])
                chk($sformatf("R3 write address v%0d", i), {16'h0, last_wr_addr}, {16'h0, a});
            @(negedge clk);
            chk($sformatf("R8 pulse ends v%0d", i), {30'h0, done, skip}, 32'h0);
        end

        // R1: bytes outside the family are ignored
        lat = 0;
        cfg_wr(2'd1, 16'h0050);
        cfg_wr(2'd3, 16'h0060);
        rd0 = n_rd; wr0 = n_wr;
        issue(8'hA8);
        issue(8'h21);
        issue(8'hE0);
        repeat (6) @(negedge clk);
        chk("R1 no access", n_rd - rd0 + n_wr - wr0, 0);
        chk("R1 pointers kept", {ptr_b, ptr_x}, {16'h0050, 16'h0060});
        chk("R1 not busy", {31'h0, busy}, 32'h0);

        // R1 / R10: opcode and register write while busy are ignored
        lat = 3;
        cfg_wr(2'd2, 16'hFFFF);
        poke(8'h50, 8'h3C);
        rd0 = n_rd; wr0 = n_wr;
        issue(8'hA0);
        chk("R8 busy during op", {31'h0, busy}, 32'h1);
        issue(8'hA4);
        cfg_wr(2'd2, 16'h0001);
        wait_done(cyc);
        chk("R10 write ignored while busy", {16'h0, lim_k}, 32'h0000FFFF);
        chk("R1 second op ignored ptr_x", {16'h0, ptr_x}, 32'h00000060);
        chk("R4 ptr_b stepped once", {16'h0, ptr_b}, 32'h00000051);
        chk("R5 no skip below limit", {31'h0, skip}, 32'h0);
        repeat (8) @(negedge clk);
        chk("R1 only one read", n_rd - rd0 + n_wr - wr0, 1);

        // R9: request hygiene seen by the memory model
        chk("R9 address held while waiting", hold_err, 0);
        chk("R9 no read/write overlap", overlap, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule